// File: doc/BRIEF.md
# Clock Frequency Readback Evaluator

This block works out the frequency, in kHz, that one clock domain is running at, given a snapshot of that domain's control words. A caller places the domain index, the global PLL-select mask, the domain's PLL control and coefficient words, its source-select word, its reference divider word and its post-divider word on the inputs. It also supplies the crystal frequency and the two VCO frequencies, all in kHz. It then pulses `start`. The inputs are captured on that pulse, so they may change while the block works.

The reference clock is taken first. It is either a fixed frequency chosen by the source code or one of the VCOs divided down. If the domain's mask bit is set, the reference is then passed through a PLL stage (multiply by N, divide by M, divide by P). A gated post-divider is applied last. All divisions share one bit-serial restoring divider. The answer appears on `freqKhz` together with a one-cycle `done` strobe, and it holds until the next request.

Top module: `freq_readback`

## Requirements
- R1: On the PLL path, when bit 0 of the PLL control word is clear, the PLL stage produces 0.
- R2: On the PLL path, when bit 0 of the PLL control word is set, the PLL stage produces ((ref*N)/M)/P in integer arithmetic. P is coefficient bits 21:16, N is bits 15:8 and M is bits 7:0.
- R3: The source code is source-select bits 1:0, and it maps as follows. Code 1 gives 0. Code 2 gives 100000 kHz. Code 0 gives the crystal frequency, except that it gives 108000 kHz when bits 17:16 are both 1.
- R4: Source code 3 gives (vco*2)/d. d is 2 when bit 31 of the reference divider word is clear, and its 6-bit divide field plus 2 when bit 31 is set.
- R5: Source-select bit 8 chooses the second VCO instead of the first. It also moves the divide field from bits 5:0 to bits 13:8 of the reference divider word. The enable is still bit 31.
- R6: The mask bit at the domain index chooses the path. When the bit is set, the PLL path is used and the post-divisor is post-divider bits 13:8 plus 2. When it is clear, the reference passes straight through and the post-divisor is bits 5:0 plus 2. Other mask bits have no effect.
- R7: When bit 31 of the post-divider word is set, the result is (clk*2)/post-divisor. When it is clear, clk is reported unchanged.
- R8: Any division by zero (M=0 or P=0) yields 0 and the request still completes.
- R9: A `start` that arrives while `busy` is high is ignored. It produces no extra result, and the result in flight is not disturbed. `busy` rises the cycle after an accepted `start` and stays high until `done`.
- R10: `done` is high for exactly one cycle, while `freqKhz` carries the result. `freqKhz` does not change while the block is idle.
- R11: After reset, `busy`, `done` and `freqKhz` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse; captures all data inputs |
| domIdx | input | IDX_W (4) | Domain index into the PLL-select mask |
| pllSelMask | input | NUM_DOM (16) | Global PLL-select mask, one bit per domain |
| pllCtrl | input | 32 | PLL control word (bit 0 = enabled) |
| pllCoef | input | 32 | PLL coefficient word (P, N, M) |
| srcSel | input | 32 | Source-select word |
| divCtl | input | 32 | Reference divider word |
| postDiv | input | 32 | Post-divider word |
| crystalKhz | input | 32 | Crystal frequency in kHz |
| vco0Khz | input | 32 | First VCO frequency in kHz |
| vco1Khz | input | 32 | Second VCO frequency in kHz |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result strobe |
| freqKhz | output | 32 | Computed frequency in kHz |

## Verification
The bench aims at the field boundaries. Code 0 is driven with only one of bits 17:16 set, which a design testing either bit alone would turn into 108000. Bit 8 cases load a nonzero low field that should be ignored, which catches a design that skips the field shift. Post-divider words carry different values in bits 13:8 and 5:0, so choosing the field by the wrong path gives a visibly different quotient, and a clear bit 31 exposes a design that divides anyway. M=0 and P=0 expose a divider that hangs or returns all ones. A second `start` with different inputs lands in the middle of a long request, so a design that restarts or emits two strobes fails.

// File: rtl/freq_rb_pkg.sv
package freq_rb_pkg;

  typedef enum logic [1:0] {
    OP_VCO  = 2'd0,
    OP_MDIV = 2'd1,
    OP_PDIV = 2'd2,
    OP_POST = 2'd3
  } divOpE;

  // strobes from control to datapath
  typedef struct packed {
    logic  capture;
    logic  loadFixed;
    logic  clearAcc;
    logic  mulN;
    logic  divGo;
    divOpE divOp;
    logic  takeQuot;
  } dpCtlT;

  // decoded snapshot state back to control
  typedef struct packed {
    logic useVco;
    logic usePll;
    logic pllOn;
    logic postOn;
    logic divDone;
  } dpStatT;

endpackage

// File: rtl/freq_rb_divider.sv
module freq_rb_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         divDone,
  output logic [W-1:0] quotient
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  remR, quoR, divR;
  logic [CW-1:0] cntR;
  logic          runR, doneR;
  logic [W:0]    shifted, diff;

  assign shifted = {remR, quoR[W-1]};
  assign diff    = shifted - {1'b0, divR};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remR  <= '0;
      quoR  <= '0;
      divR  <= '0;
      cntR  <= '0;
      runR  <= 1'b0;
      doneR <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (go) begin
        if (divisor == '0) begin
          quoR  <= '0;
          runR  <= 1'b0;
          doneR <= 1'b1;
        end else begin
          quoR <= dividend;
          remR <= '0;
          divR <= divisor;
          cntR <= CW'(W);
          runR <= 1'b1;
        end
      end else if (runR) begin
        if (!diff[W]) begin
          remR <= diff[W-1:0];
          quoR <= {quoR[W-2:0], 1'b1};
        end else begin
          remR <= shifted[W-1:0];
          quoR <= {quoR[W-2:0], 1'b0};
        end
        cntR <= cntR - CW'(1);
        if (cntR == CW'(1)) begin
          runR  <= 1'b0;
          doneR <= 1'b1;
        end
      end
    end
  end

  assign divDone  = doneR;
  assign quotient = quoR;
endmodule

// File: rtl/freq_rb_datapath.sv
module freq_rb_datapath
  import freq_rb_pkg::*;
#(
  parameter int W             = 32,
  parameter int NUM_DOM       = 16,
  parameter int IDX_W         = 4,
  parameter int FIXED_HI_KHZ  = 108000,
  parameter int FIXED_REF_KHZ = 100000
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtlT              ctl,
  output dpStatT             stat,
  input  logic [IDX_W-1:0]   domIdx,
  input  logic [NUM_DOM-1:0] pllSelMask,
  input  logic [31:0]        pllCtrl,
  input  logic [31:0]        pllCoef,
  input  logic [31:0]        srcSel,
  input  logic [31:0]        divCtl,
  input  logic [31:0]        postDiv,
  input  logic [W-1:0]       crystalKhz,
  input  logic [W-1:0]       vco0Khz,
  input  logic [W-1:0]       vco1Khz,
  output logic [W-1:0]       freqKhz
);
  localparam int FW  = 6;
  localparam int SDW = FW + 1;

  logic [W-1:0]   fixedR, vcoR, accR;
  logic [SDW-1:0] vcoSdivR, postSdivR;
  logic [7:0]     nR, mR;
  logic [FW-1:0]  pR;
  logic           useVcoR, usePllR, pllOnR, postOnR;
  logic           pathPll;
  logic [FW-1:0]  vcoField, postField;
  logic [W-1:0]   dvdSel, dvsSel, quot;
  logic           divDone;
  logic           unusedBits;

  assign pathPll   = pllSelMask[domIdx];
  assign vcoField  = srcSel[8] ? divCtl[13:8] : divCtl[5:0];
  assign postField = pathPll ? postDiv[13:8] : postDiv[5:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fixedR    <= '0;
      vcoR      <= '0;
      vcoSdivR  <= '0;
      postSdivR <= '0;
      nR        <= '0;
      mR        <= '0;
      pR        <= '0;
      useVcoR   <= 1'b0;
      usePllR   <= 1'b0;
      pllOnR    <= 1'b0;
      postOnR   <= 1'b0;
    end else if (ctl.capture) begin
      useVcoR <= (srcSel[1:0] == 2'd3);
      unique case (srcSel[1:0])
        2'd0:    fixedR <= (&srcSel[17:16]) ? W'(FIXED_HI_KHZ) : crystalKhz;
        2'd2:    fixedR <= W'(FIXED_REF_KHZ);
        default: fixedR <= '0;
      endcase
      vcoR      <= srcSel[8] ? vco1Khz : vco0Khz;
      vcoSdivR  <= divCtl[31] ? ({1'b0, vcoField} + SDW'(2)) : SDW'(2);
      usePllR   <= pathPll;
      pllOnR    <= pllCtrl[0];
      pR        <= pllCoef[21:16];
      nR        <= pllCoef[15:8];
      mR        <= pllCoef[7:0];
      postOnR   <= postDiv[31];
      postSdivR <= {1'b0, postField} + SDW'(2);
    end
  end

  always_comb begin
    unique case (ctl.divOp)
      OP_VCO: begin
        dvdSel = vcoR << 1;
        dvsSel = W'(vcoSdivR);
      end
      OP_MDIV: begin
        dvdSel = accR;
        dvsSel = W'(mR);
      end
      OP_PDIV: begin
        dvdSel = accR;
        dvsSel = W'(pR);
      end
      default: begin
        dvdSel = accR << 1;
        dvsSel = W'(postSdivR);
      end
    endcase
  end

  freq_rb_divider #(.W(W)) uDiv (
    .clk      (clk),
    .rstN     (rstN),
    .go       (ctl.divGo),
    .dividend (dvdSel),
    .divisor  (dvsSel),
    .divDone  (divDone),
    .quotient (quot)
  );

  always_ff @(posedge clk) begin
    if (!rstN)              accR <= '0;
    else if (ctl.clearAcc)  accR <= '0;
    else if (ctl.loadFixed) accR <= fixedR;
    else if (ctl.mulN)      accR <= accR * W'(nR);
    else if (ctl.takeQuot)  accR <= quot;
  end

  assign stat = '{useVco: useVcoR, usePll: usePllR, pllOn: pllOnR,
                  postOn: postOnR, divDone: divDone};
  assign freqKhz = accR;

  assign unusedBits = ^{pllCtrl[31:1], pllCoef[31:22], srcSel[31:18],
                        srcSel[15:9], srcSel[7:2], divCtl[30:14],
                        divCtl[7:6], postDiv[30:14], postDiv[7:6]};
endmodule

// File: rtl/freq_rb_control.sv
module freq_rb_control
  import freq_rb_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  dpStatT stat,
  output dpCtlT  ctl,
  output logic   busy,
  output logic   done
);
  typedef enum logic [3:0] {
    S_IDLE, S_SRC, S_VCO, S_PLL, S_MDIV, S_PDIV, S_POSTCHK, S_POST, S_DONE
  } stateE;

  stateE stateR, stateNx;
  logic  launchedR;

  always_comb begin
    ctl     = '0;
    stateNx = stateR;
    unique case (stateR)
      S_IDLE: if (start) begin
        ctl.capture = 1'b1;
        stateNx     = S_SRC;
      end
      S_SRC: begin
        if (stat.useVco) stateNx = S_VCO;
        else begin
          ctl.loadFixed = 1'b1;
          stateNx       = S_PLL;
        end
      end
      S_PLL: begin
        if (!stat.usePll) stateNx = S_POSTCHK;
        else if (!stat.pllOn) begin
          ctl.clearAcc = 1'b1;
          stateNx      = S_POSTCHK;
        end else begin
          ctl.mulN = 1'b1;
          stateNx  = S_MDIV;
        end
      end
      S_POSTCHK: stateNx = stat.postOn ? S_POST : S_DONE;
      S_DONE:    stateNx = S_IDLE;
      default: begin
        // one of the four divide states
        unique case (stateR)
          S_VCO:   ctl.divOp = OP_VCO;
          S_MDIV:  ctl.divOp = OP_MDIV;
          S_PDIV:  ctl.divOp = OP_PDIV;
          default: ctl.divOp = OP_POST;
        endcase
        if (!launchedR) ctl.divGo = 1'b1;
        else if (stat.divDone) begin
          ctl.takeQuot = 1'b1;
          unique case (stateR)
            S_VCO:   stateNx = S_PLL;
            S_MDIV:  stateNx = S_PDIV;
            S_PDIV:  stateNx = S_POSTCHK;
            default: stateNx = S_DONE;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateR    <= S_IDLE;
      launchedR <= 1'b0;
    end else begin
      stateR <= stateNx;
      if (ctl.divGo)         launchedR <= 1'b1;
      else if (ctl.takeQuot) launchedR <= 1'b0;
    end
  end

  assign busy = (stateR != S_IDLE);
  assign done = (stateR == S_DONE);
endmodule

// File: rtl/freq_readback.sv
module freq_readback
  import freq_rb_pkg::*;
#(
  parameter int   W             = 32,
  parameter int   NUM_DOM       = 16,
  parameter int   FIXED_HI_KHZ  = 108000,
  parameter int   FIXED_REF_KHZ = 100000,
  localparam int  IDX_W         = $clog2(NUM_DOM)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [IDX_W-1:0]   domIdx,
  input  logic [NUM_DOM-1:0] pllSelMask,
  input  logic [31:0]        pllCtrl,
  input  logic [31:0]        pllCoef,
  input  logic [31:0]        srcSel,
  input  logic [31:0]        divCtl,
  input  logic [31:0]        postDiv,
  input  logic [W-1:0]       crystalKhz,
  input  logic [W-1:0]       vco0Khz,
  input  logic [W-1:0]       vco1Khz,
  output logic               busy,
  output logic               done,
  output logic [W-1:0]       freqKhz
);
  dpCtlT  ctl;
  dpStatT stat;

  freq_rb_control uCtl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .stat (stat),
    .ctl  (ctl),
    .busy (busy),
    .done (done)
  );

  freq_rb_datapath #(
    .W(W), .NUM_DOM(NUM_DOM), .IDX_W(IDX_W),
    .FIXED_HI_KHZ(FIXED_HI_KHZ), .FIXED_REF_KHZ(FIXED_REF_KHZ)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .stat       (stat),
    .domIdx     (domIdx),
    .pllSelMask (pllSelMask),
    .pllCtrl    (pllCtrl),
    .pllCoef    (pllCoef),
    .srcSel     (srcSel),
    .divCtl     (divCtl),
    .postDiv    (postDiv),
    .crystalKhz (crystalKhz),
    .vco0Khz    (vco0Khz),
    .vco1Khz    (vco1Khz),
    .freqKhz    (freqKhz)
  );
endmodule

// File: rtl/freq_rb_checker.sv
module freq_rb_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] freqKhz
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R9
  accept_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  // R10
  idle_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(freqKhz));
endmodule

bind freq_readback freq_rb_checker #(.W(W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .freqKhz (freqKhz)
);

// File: tb/sim_freq_readback.sv
module sim_freq_readback;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] XTAL = 32'd27000;
  localparam logic [31:0] VCO0 = 32'd1600000;
  localparam logic [31:0] VCO1 = 32'd1200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  domIdx = '0;
  logic [15:0] pllSelMask = '0;
  logic [31:0] pllCtrl = '0, pllCoef = '0, srcSel = '0, divCtl = '0, postDiv = '0;
  logic        busy, done;
  logic [31:0] freqKhz;

  int nTests = 0;
  int nFails = 0;
  int nDone  = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        prevDone = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  freq_readback u0 (
    .clk(clk), .rstN(rstN), .start(start), .domIdx(domIdx),
    .pllSelMask(pllSelMask), .pllCtrl(pllCtrl), .pllCoef(pllCoef),
    .srcSel(srcSel), .divCtl(divCtl), .postDiv(postDiv),
    .crystalKhz(XTAL), .vco0Khz(VCO0), .vco1Khz(VCO1),
    .busy(busy), .done(done), .freqKhz(freqKhz)
  );

  function automatic logic [31:0] model(input logic [3:0] d, input logic [15:0] m,
      input logic [31:0] ctrl, coef, src, dctl, post);
    logic [31:0] refK, clkK, sd, vco;
    logic [5:0]  fld;
    case (src[1:0])
      2'd0: refK = (src[17:16] == 2'b11) ? 32'd108000 : XTAL;
      2'd1: refK = 32'd0;
      2'd2: refK = 32'd100000;
      default: begin
        vco = src[8] ? VCO1 : VCO0;
        fld = src[8] ? dctl[13:8] : dctl[5:0];
        sd  = dctl[31] ? 32'(fld) + 32'd2 : 32'd2;
        refK = (vco * 2) / sd;
      end
    endcase
    if (m[d]) begin
      if (!ctrl[0] || coef[7:0] == 0 || coef[21:16] == 0) clkK = 0;
      else clkK = ((refK * 32'(coef[15:8])) / 32'(coef[7:0])) / 32'(coef[21:16]);
      fld = post[13:8];
    end else begin
      clkK = refK;
      fld  = post[5:0];
    end
    if (post[31]) clkK = (clkK * 2) / (32'(fld) + 32'd2);
    return clkK;
  endfunction

  task automatic check(input string req, input logic [31:0] act, exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] d, input logic [15:0] m,
      input logic [31:0] ctrl, coef, src, dctl, post);
    domIdx = d; pllSelMask = m; pllCtrl = ctrl; pllCoef = coef;
    srcSel = src; divCtl = dctl; postDiv = post;
  endtask

  task automatic run(input string tag, input logic [3:0] d, input logic [15:0] m,
      input logic [31:0] ctrl, coef, src, dctl, post);
    while (busy) @(negedge clk);
    drive(d, m, ctrl, coef, src, dctl, post);
    expQ.push_back(model(d, m, ctrl, coef, src, dctl, post));
    tagQ.push_back(tag);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (done && prevDone) check("R10 done width", 32'd2, 32'd1);
      if (done) begin
        nDone++;
        if (expQ.size() == 0) check("R9 unexpected done", 32'd1, 32'd0);
        else check(tagQ.pop_front(), freqKhz, expQ.pop_front());
      end
      prevDone = done;
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        check("R11 busy after reset", 32'(busy), 0);
        check("R11 done after reset", 32'(done), 0);
        check("R11 freq after reset", freqKhz, 0);

        run("R3 code0 crystal",        4'd3, 16'h0000, 0, 0, 32'h0000_0000, 0, 0);
        run("R3 code0 108000",         4'd3, 16'h0000, 0, 0, 32'h0003_0000, 0, 0);
        run("R3 code0 one bit only",   4'd3, 16'h0000, 0, 0, 32'h0001_0000, 0, 0);
        run("R3 code1 zero",           4'd3, 16'h0000, 0, 0, 32'h0003_0001, 0, 0);
        run("R3 code2 100000",         4'd3, 16'h0000, 0, 0, 32'h0000_0002, 0, 0);
        run("R4 vco default div",      4'd3, 16'h0000, 0, 0, 32'h0000_0003, 32'h0000_0006, 0);
        run("R4 vco field div",        4'd3, 16'h0000, 0, 0, 32'h0000_0003, 32'h8000_0006, 0);
        run("R5 second vco shifted",   4'd3, 16'h0000, 0, 0, 32'h0000_0103, 32'h8000_0A3F, 0);
        run("R2 pll enabled",          4'd3, 16'h0008, 1, 32'h0002_3201, 0, 0, 0);
        run("R1 pll disabled",         4'd3, 16'h0008, 0, 32'h0002_3201, 0, 0, 0);
        run("R8 M zero",               4'd3, 16'h0008, 1, 32'h0002_3200, 0, 0, 0);
        run("R8 P zero",               4'd3, 16'h0008, 1, 32'h0000_3201, 0, 0, 32'h8000_0203);
        run("R6 pll post field",       4'd3, 16'h0008, 1, 32'h0002_3201, 0, 0, 32'h8000_0203);
        run("R6 div post field",       4'd3, 16'h0000, 0, 0, 32'h0000_0002, 0, 32'h8000_0203);
        run("R7 post gate clear",      4'd3, 16'h0000, 0, 0, 32'h0000_0002, 0, 32'h0000_0203);
        run("R6 other mask bits",      4'd3, 16'hFFF7, 1, 32'h0002_3201, 32'h0000_0002, 0, 0);
        run("R6 top domain pll",       4'd15, 16'h8000, 1, 32'h0001_0401, 32'h0000_0002, 0, 0);

        // R9: second start during a long request is ignored
        run("R9 in-flight result",     4'd3, 16'h0000, 0, 0, 32'h0000_0003, 32'h8000_0004, 32'h8000_0001);
        repeat (5) @(negedge clk);
        drive(4'd3, 16'h0000, 0, 0, 32'h0000_0002, 0, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        repeat (120) @(negedge clk);
        check("R9 done count", 32'(nDone), 32'd18);
        check("R9 queue drained", 32'(expQ.size()), 0);
      end
      begin
        repeat (150000) @(posedge clk);
        nTests++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule